// File: doc/BRIEF.md
# Token-Driven Memory Request Port

This block is the request engine that sits behind one input queue of a shared on-chip memory. The owning processor pushes 16-bit tokens. The engine decodes each command token into one of eight operations: a single read, a single write, a port setup, a burst-address setup, a burst read, a burst write, a lock acquire or a lock release. It then drives one memory access per cycle toward the shared array and steers read results into one of several output queues.

Every port runs in one of three modes. In address-data mode the port supplies both addresses and write data. In address-only mode it supplies write addresses, and the write data comes from a partner port's stream. In data-only mode the port offers its own tokens, unchanged, as a data stream for such a partner, and only its own setup commands are still executed. Mode, destination queue and partner are changed by in-band setup commands. Queues are modelled as valid/ready streams. Grants for the memory and for the locks arrive from arbitration outside the block.

Top module: `mem_req_port`

## Requirements
- R1: After reset the port is in address-data mode with destination queue 0 and partner 0. No memory request, output valid, share valid, lock request or lock release is asserted.
- R2: A single write (type 1 in bits [15:13], address in the low bits) in address-data mode writes the next token of the port's own stream to that address. No memory request is made while that data token is absent.
- R3: A single read (type 0) is neither accepted nor issued while the destination queue reports no room. After a granted read, the stored word appears on `out_data_o`, with exactly the destination bit of `out_valid_o` set, one cycle later.
- R4: A port setup command (type 2) sets mode from bits [1:0] (0 address-data, 1 address-only, 2 data-only, 3 treated as address-data), the destination queue from bits [3:2] and the partner port from bits [5:4]. The new values apply from the next command.
- R5: In address-only mode, a write or burst write takes its data from the partner stream selected by the setup, and handshakes only with that stream. Setup commands still execute from the port's own stream.
- R6: In data-only mode, every own token whose type is not 2 is offered unchanged on the share stream and is not executed. A type-2 token is executed and is not offered.
- R7: A burst read (type 4) is followed by a length token (bits [7:0], 0 to 255). It reads that many consecutive addresses starting at the burst address pointer, producing one output word per access. A length of 0 performs no access.
- R8: A burst write (type 5) is followed by a length token. It writes that many data words, taken from the mode's data source, to consecutive addresses starting at the pointer.
- R9: A burst-address setup (type 3) loads the pointer from the command's address bits. After a burst, the pointer rests one past the last address used, so the next burst continues from there.
- R10: A lock acquire (type 6, lock id in bits [1:0]) holds the lock request and id until granted. No later token is consumed before the grant.
- R11: A lock release (type 7, id in bits [1:0]) produces a single-cycle release pulse carrying that id.
- R12: Requests execute in arrival order with at most one memory access per cycle. Every accepted read or write word costs exactly one granted access, and a request waiting for grant keeps its address and direction.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| tok_valid_i | input | 1 | Own token stream valid |
| tok_data_i | input | 16 | Own token |
| tok_ready_o | output | 1 | Own token consumed |
| peer_valid_i | input | N_PEER | Partner data streams valid |
| peer_data_i | input | 16*N_PEER | Partner data words, port k at [16k+15:16k] |
| peer_ready_o | output | N_PEER | Partner word consumed |
| share_valid_o | output | 1 | Data-only token offered to a partner |
| share_data_o | output | 16 | Offered token |
| share_ready_i | input | 1 | Offered token taken |
| mem_req_o | output | 1 | Memory access request |
| mem_we_o | output | 1 | Request is a write |
| mem_addr_o | output | AW | Access address |
| mem_wdata_o | output | 16 | Write data |
| mem_gnt_i | input | 1 | Access granted this cycle |
| mem_rdata_i | input | 16 | Read data, one cycle after a granted read |
| out_room_i | input | N_OUT | Output queue k can take a word |
| out_valid_o | output | N_OUT | Push to output queue k |
| out_data_o | output | 16 | Read result |
| mtx_req_o | output | 1 | Lock acquire request |
| mtx_rel_o | output | 1 | Lock release pulse |
| mtx_id_o | output | MW | Lock id |
| mtx_gnt_i | input | 1 | Lock granted |

## Verification
The assertions check on every cycle that reads are only requested toward a queue with room and return as exactly one one-hot push. They also check that a stalled memory or lock request stays stable, that an unaccepted share offer holds, and that release lasts a single cycle. Data correctness cannot be seen by these properties. That includes words landing at the right address, data taken from the right partner, bursts continuing from the pointer, and a zero-length burst doing nothing. The bench's sweeps show these by writing computed patterns under a pseudo-random grant and reading them back. Only the scenarios can show that data-only tokens pass through unexecuted and that mode and destination switch in-band.

// File: rtl/mrp_pkg.sv
package mrp_pkg;
  localparam int TOK_W  = 16;
  localparam int OP_LSB = 13;

  typedef enum logic [2:0] {
    OP_RD   = 3'd0,
    OP_WR   = 3'd1,
    OP_CFGP = 3'd2,
    OP_CFGA = 3'd3,
    OP_BRD  = 3'd4,
    OP_BWR  = 3'd5,
    OP_LOCK = 3'd6,
    OP_FREE = 3'd7
  } op_e;

  typedef enum logic [1:0] {
    MD_AD = 2'd0,
    MD_AO = 2'd1,
    MD_DO = 2'd2
  } mode_e;

  typedef enum logic [2:0] {
    S_IDLE, S_RD, S_WR, S_BLEN, S_BRD, S_BWR, S_LOCK, S_FREE
  } state_e;
endpackage

// File: rtl/mrp_decode.sv
module mrp_decode
  import mrp_pkg::*;
#(
  parameter int AW = 8,
  parameter int OW = 2,
  parameter int PW = 2,
  parameter int MW = 2,
  parameter int LW = 8
) (
  input  logic [TOK_W-1:0] tok_i,
  output op_e              op_o,
  output logic [AW-1:0]    addr_o,
  output mode_e            mode_o,
  output logic [OW-1:0]    dest_o,
  output logic [PW-1:0]    part_o,
  output logic [MW-1:0]    mtx_o,
  output logic [LW-1:0]    len_o
);
  localparam int DEST_LSB = 2;
  localparam int PART_LSB = DEST_LSB + OW;

  always_comb begin
    op_o   = op_e'(tok_i[TOK_W-1:OP_LSB]);
    addr_o = tok_i[AW-1:0];
    unique case (tok_i[1:0])
      2'd1:    mode_o = MD_AO;
      2'd2:    mode_o = MD_DO;
      default: mode_o = MD_AD;
    endcase
    dest_o = tok_i[DEST_LSB +: OW];
    part_o = tok_i[PART_LSB +: PW];
    mtx_o  = tok_i[MW-1:0];
    len_o  = tok_i[LW-1:0];
  end
endmodule

// File: rtl/mrp_cfg_regs.sv
module mrp_cfg_regs
  import mrp_pkg::*;
#(
  parameter int OW = 2,
  parameter int PW = 2
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          we_i,
  input  mode_e         mode_i,
  input  logic [OW-1:0] dest_i,
  input  logic [PW-1:0] part_i,
  output mode_e         mode_o,
  output logic [OW-1:0] dest_o,
  output logic [PW-1:0] part_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      mode_o <= MD_AD;
      dest_o <= '0;
      part_o <= '0;
    end else if (we_i) begin
      mode_o <= mode_i;
      dest_o <= dest_i;
      part_o <= part_i;
    end
  end
endmodule

// File: rtl/mrp_burst_ctr.sv
module mrp_burst_ctr #(
  parameter int AW = 8,
  parameter int LW = 8
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          base_we_i,
  input  logic [AW-1:0] base_i,
  input  logic          cnt_we_i,
  input  logic [LW-1:0] cnt_i,
  input  logic          step_i,
  output logic [AW-1:0] addr_o,
  output logic          last_o
);
  logic [LW-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      addr_o <= '0;
      cnt_q  <= '0;
    end else begin
      if (base_we_i)   addr_o <= base_i;
      else if (step_i) addr_o <= addr_o + 1'b1;
      if (cnt_we_i)    cnt_q <= cnt_i;
      else if (step_i) cnt_q <= cnt_q - 1'b1;
    end
  end

  assign last_o = (cnt_q == LW'(1));
endmodule

// File: rtl/mem_req_port.sv
module mem_req_port
  import mrp_pkg::*;
#(
  parameter int AW     = 8,
  parameter int N_OUT  = 4,
  parameter int N_PEER = 4,
  parameter int N_MTX  = 4,
  parameter int LW     = 8
) (
  input  logic                    clk_i,
  input  logic                    rst_ni,
  input  logic                    tok_valid_i,
  input  logic [15:0]             tok_data_i,
  output logic                    tok_ready_o,
  input  logic [N_PEER-1:0]       peer_valid_i,
  input  logic [16*N_PEER-1:0]    peer_data_i,
  output logic [N_PEER-1:0]       peer_ready_o,
  output logic                    share_valid_o,
  output logic [15:0]             share_data_o,
  input  logic                    share_ready_i,
  output logic                    mem_req_o,
  output logic                    mem_we_o,
  output logic [AW-1:0]           mem_addr_o,
  output logic [15:0]             mem_wdata_o,
  input  logic                    mem_gnt_i,
  input  logic [15:0]             mem_rdata_i,
  input  logic [N_OUT-1:0]        out_room_i,
  output logic [N_OUT-1:0]        out_valid_o,
  output logic [15:0]             out_data_o,
  output logic                    mtx_req_o,
  output logic                    mtx_rel_o,
  output logic [((N_MTX>1)?$clog2(N_MTX):1)-1:0] mtx_id_o,
  input  logic                    mtx_gnt_i
);
  localparam int OW = (N_OUT  > 1) ? $clog2(N_OUT)  : 1;
  localparam int PW = (N_PEER > 1) ? $clog2(N_PEER) : 1;
  localparam int MW = (N_MTX  > 1) ? $clog2(N_MTX)  : 1;

  op_e           d_op;
  mode_e         d_mode, mode_q;
  logic [AW-1:0] d_addr, addr_q, addr_d, agen_addr;
  logic [OW-1:0] d_dest, dest_q, rd_dest_q;
  logic [PW-1:0] d_part, part_q;
  logic [MW-1:0] d_mtx, id_q, id_d;
  logic [LW-1:0] d_len;
  state_e        state_q, state_d;
  logic          bw_q, bw_d;
  logic          cfg_we, base_we, cnt_we, step, rd_fire, src_pop, rd_pend_q, b_last;
  logic          src_valid;
  logic [15:0]   src_data;

  mrp_decode #(.AW(AW), .OW(OW), .PW(PW), .MW(MW), .LW(LW)) u_dec (
    .tok_i(tok_data_i), .op_o(d_op), .addr_o(d_addr), .mode_o(d_mode),
    .dest_o(d_dest), .part_o(d_part), .mtx_o(d_mtx), .len_o(d_len)
  );

  mrp_cfg_regs #(.OW(OW), .PW(PW)) u_cfg (
    .clk_i, .rst_ni, .we_i(cfg_we), .mode_i(d_mode), .dest_i(d_dest),
    .part_i(d_part), .mode_o(mode_q), .dest_o(dest_q), .part_o(part_q)
  );

  mrp_burst_ctr #(.AW(AW), .LW(LW)) u_bctr (
    .clk_i, .rst_ni, .base_we_i(base_we), .base_i(d_addr), .cnt_we_i(cnt_we),
    .cnt_i(d_len), .step_i(step), .addr_o(agen_addr), .last_o(b_last)
  );

  // write data source follows the mode
  always_comb begin
    if (mode_q == MD_AO) begin
      src_valid = peer_valid_i[part_q];
      src_data  = peer_data_i[16*part_q +: 16];
    end else begin
      src_valid = tok_valid_i;
      src_data  = tok_data_i;
    end
  end

  assign mem_wdata_o  = src_data;
  assign share_data_o = tok_data_i;
  assign mtx_id_o     = id_q;

  always_comb begin
    state_d       = state_q;
    addr_d        = addr_q;
    id_d          = id_q;
    bw_d          = bw_q;
    tok_ready_o   = 1'b0;
    peer_ready_o  = '0;
    share_valid_o = 1'b0;
    mem_req_o     = 1'b0;
    mem_we_o      = 1'b0;
    mem_addr_o    = addr_q;
    cfg_we        = 1'b0;
    base_we       = 1'b0;
    cnt_we        = 1'b0;
    step          = 1'b0;
    rd_fire       = 1'b0;
    src_pop       = 1'b0;
    mtx_req_o     = 1'b0;
    mtx_rel_o     = 1'b0;
    unique case (state_q)
      S_IDLE: if (tok_valid_i) begin
        if (mode_q == MD_DO) begin
          if (d_op == OP_CFGP) begin
            tok_ready_o = 1'b1;
            cfg_we      = 1'b1;
          end else begin
            share_valid_o = 1'b1;
            tok_ready_o   = share_ready_i;
          end
        end else begin
          unique case (d_op)
            OP_RD: if (out_room_i[dest_q]) begin
              tok_ready_o = 1'b1;
              addr_d      = d_addr;
              state_d     = S_RD;
            end
            OP_WR: begin
              tok_ready_o = 1'b1;
              addr_d      = d_addr;
              state_d     = S_WR;
            end
            OP_CFGP: begin
              tok_ready_o = 1'b1;
              cfg_we      = 1'b1;
            end
            OP_CFGA: begin
              tok_ready_o = 1'b1;
              base_we     = 1'b1;
            end
            OP_BRD, OP_BWR: begin
              tok_ready_o = 1'b1;
              bw_d        = (d_op == OP_BWR);
              state_d     = S_BLEN;
            end
            OP_LOCK: begin
              tok_ready_o = 1'b1;
              id_d        = d_mtx;
              state_d     = S_LOCK;
            end
            default: begin
              tok_ready_o = 1'b1;
              id_d        = d_mtx;
              state_d     = S_FREE;
            end
          endcase
        end
      end
      S_RD: begin
        mem_req_o = out_room_i[dest_q];
        if (out_room_i[dest_q] && mem_gnt_i) begin
          rd_fire = 1'b1;
          state_d = S_IDLE;
        end
      end
      S_WR: begin
        mem_req_o = src_valid;
        mem_we_o  = 1'b1;
        if (src_valid && mem_gnt_i) begin
          src_pop = 1'b1;
          state_d = S_IDLE;
        end
      end
      S_BLEN: if (tok_valid_i) begin
        tok_ready_o = 1'b1;
        if (d_len == '0) begin
          state_d = S_IDLE;
        end else begin
          cnt_we  = 1'b1;
          state_d = bw_q ? S_BWR : S_BRD;
        end
      end
      S_BRD: begin
        mem_addr_o = agen_addr;
        mem_req_o  = out_room_i[dest_q];
        if (out_room_i[dest_q] && mem_gnt_i) begin
          rd_fire = 1'b1;
          step    = 1'b1;
          if (b_last) state_d = S_IDLE;
        end
      end
      S_BWR: begin
        mem_addr_o = agen_addr;
        mem_req_o  = src_valid;
        mem_we_o   = 1'b1;
        if (src_valid && mem_gnt_i) begin
          src_pop = 1'b1;
          step    = 1'b1;
          if (b_last) state_d = S_IDLE;
        end
      end
      S_LOCK: begin
        mtx_req_o = 1'b1;
        if (mtx_gnt_i) state_d = S_IDLE;
      end
      default: begin
        mtx_rel_o = 1'b1;
        state_d   = S_IDLE;
      end
    endcase
    if (src_pop) begin
      if (mode_q == MD_AO) peer_ready_o[part_q] = 1'b1;
      else                 tok_ready_o          = 1'b1;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q   <= S_IDLE;
      addr_q    <= '0;
      id_q      <= '0;
      bw_q      <= 1'b0;
      rd_pend_q <= 1'b0;
      rd_dest_q <= '0;
    end else begin
      state_q   <= state_d;
      addr_q    <= addr_d;
      id_q      <= id_d;
      bw_q      <= bw_d;
      rd_pend_q <= rd_fire;
      rd_dest_q <= dest_q;
    end
  end

  always_comb begin
    out_valid_o = '0;
    if (rd_pend_q) out_valid_o[rd_dest_q] = 1'b1;
  end
  assign out_data_o = mem_rdata_i;
endmodule

// File: rtl/mrp_port_chk.sv
module mrp_port_chk #(
  parameter int N_OUT = 4,
  parameter int AW    = 8,
  parameter int MW    = 2,
  parameter int OW    = 2
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             mem_req_i,
  input logic             mem_we_i,
  input logic             mem_gnt_i,
  input logic [AW-1:0]    mem_addr_i,
  input logic [N_OUT-1:0] out_room_i,
  input logic [N_OUT-1:0] out_valid_i,
  input logic [OW-1:0]    dest_i,
  input logic             mtx_req_i,
  input logic             mtx_gnt_i,
  input logic [MW-1:0]    mtx_id_i,
  input logic             mtx_rel_i,
  input logic             share_valid_i,
  input logic             share_ready_i,
  input logic [15:0]      share_data_i
);
  a_r3_read_room: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_req_i && !mem_we_i |-> out_room_i[dest_i]);

  a_r3_read_return: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_req_i && !mem_we_i && mem_gnt_i |=> $countones(out_valid_i) == 1);

  a_r3_onehot_push: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(out_valid_i));

  a_r12_req_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_req_i && !mem_gnt_i |=> mem_req_i && $stable(mem_addr_i) && $stable(mem_we_i));

  a_r10_lock_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mtx_req_i && !mtx_gnt_i |=> mtx_req_i && $stable(mtx_id_i));

  a_r11_rel_pulse: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mtx_rel_i |=> !mtx_rel_i);

  a_r6_share_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    share_valid_i && !share_ready_i |=> share_valid_i && $stable(share_data_i));
endmodule

bind mem_req_port mrp_port_chk #(
  .N_OUT(N_OUT), .AW(AW), .MW(MW), .OW(OW)
) u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .mem_req_i(mem_req_o), .mem_we_i(mem_we_o),
  .mem_gnt_i(mem_gnt_i), .mem_addr_i(mem_addr_o), .out_room_i(out_room_i),
  .out_valid_i(out_valid_o), .dest_i(dest_q), .mtx_req_i(mtx_req_o),
  .mtx_gnt_i(mtx_gnt_i), .mtx_id_i(mtx_id_o), .mtx_rel_i(mtx_rel_o),
  .share_valid_i(share_valid_o), .share_ready_i(share_ready_i),
  .share_data_i(share_data_o)
);

// File: tb/mem_req_port_tb_top.sv
`timescale 1ns/1ps
module mem_req_port_tb_top;
  localparam int AW = 8;
  localparam int NO = 4;
  localparam int NP = 4;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #4 clk = ~clk;

  logic              tok_valid = 1'b0;
  logic [15:0]       tok_data = '0;
  logic              tok_ready;
  logic [NP-1:0]     peer_valid = '0;
  logic [16*NP-1:0]  peer_data = '0;
  logic [NP-1:0]     peer_ready;
  logic              share_valid;
  logic [15:0]       share_data;
  logic              share_ready = 1'b1;
  logic              mem_req, mem_we, mem_gnt;
  logic [AW-1:0]     mem_addr;
  logic [15:0]       mem_wdata;
  logic [15:0]       mem_rdata = '0;
  logic [NO-1:0]     out_room = '1;
  logic [NO-1:0]     out_valid;
  logic [15:0]       out_data;
  logic              mtx_req, mtx_rel;
  logic [1:0]        mtx_id;
  logic              mtx_gnt = 1'b0;
  logic [7:0]        lfsr = 8'h5B;

  mem_req_port #(.AW(AW), .N_OUT(NO), .N_PEER(NP)) dut_i (
    .clk_i(clk), .rst_ni(rst_n), .tok_valid_i(tok_valid), .tok_data_i(tok_data),
    .tok_ready_o(tok_ready), .peer_valid_i(peer_valid), .peer_data_i(peer_data),
    .peer_ready_o(peer_ready), .share_valid_o(share_valid), .share_data_o(share_data),
    .share_ready_i(share_ready), .mem_req_o(mem_req), .mem_we_o(mem_we),
    .mem_addr_o(mem_addr), .mem_wdata_o(mem_wdata), .mem_gnt_i(mem_gnt),
    .mem_rdata_i(mem_rdata), .out_room_i(out_room), .out_valid_o(out_valid),
    .out_data_o(out_data), .mtx_req_o(mtx_req), .mtx_rel_o(mtx_rel),
    .mtx_id_o(mtx_id), .mtx_gnt_i(mtx_gnt)
  );

  int checks = 0, fails = 0;
  int out_cnt = 0, share_cnt = 0, rel_cnt = 0, acc_cnt = 0, exp_acc = 0;
  logic [1:0]  rel_id;
  logic [15:0] cap_data [0:127];
  int          cap_port [0:127];
  logic [15:0] shr_data [0:15];
  logic [15:0] bmem [0:255];

  assign mem_gnt = lfsr[0] | lfsr[3];
  always @(posedge clk) begin
    #2 lfsr = {lfsr[6:0], lfsr[7] ^ lfsr[5] ^ lfsr[4] ^ lfsr[3]};
  end

  always @(posedge clk) begin
    if (mem_req && mem_gnt) begin
      acc_cnt <= acc_cnt + 1;
      if (mem_we) bmem[mem_addr] <= mem_wdata;
      else        mem_rdata <= bmem[mem_addr];
    end
  end

  always @(negedge clk) begin
    if (rst_n) begin
      for (int k = 0; k < NO; k++) begin
        if (out_valid[k] && out_cnt < 128) begin
          cap_data[out_cnt] = out_data;
          cap_port[out_cnt] = k;
          out_cnt++;
        end
      end
      if (share_valid && share_ready && share_cnt < 16) begin
        shr_data[share_cnt] = share_data;
        share_cnt++;
      end
      if (mtx_rel) begin
        rel_cnt++;
        rel_id = mtx_id;
      end
    end
  end

  function automatic logic [15:0] pat(input int a, input int s);
    return 16'((a * 40503 + s * 7919) ^ 16'h5A5A);
  endfunction

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic send(input logic [15:0] d);
    @(posedge clk); #1;
    tok_valid = 1'b1;
    tok_data  = d;
    @(negedge clk);
    while (!tok_ready) @(negedge clk);
    @(posedge clk); #1;
    tok_valid = 1'b0;
  endtask

  task automatic send_peer(input int k, input logic [15:0] d);
    @(posedge clk); #1;
    peer_valid[k] = 1'b1;
    peer_data[16*k +: 16] = d;
    @(negedge clk);
    while (!peer_ready[k]) @(negedge clk);
    @(posedge clk); #1;
    peer_valid[k] = 1'b0;
  endtask

  task automatic wait_out(input int n);
    int t = 0;
    while (out_cnt < n && t < 3000) begin
      @(negedge clk);
      t++;
    end
  endtask

  task automatic wr(input int a, input logic [15:0] d);
    send(16'h2000 | 16'(a));
    send(d);
    exp_acc++;
  endtask

  task automatic rd_chk(input int a, input logic [15:0] e, input int port, input string req);
    int n = out_cnt;
    send(16'h0000 | 16'(a));
    exp_acc++;
    wait_out(n + 1);
    chk(out_cnt > n && cap_data[n] == e && cap_port[n] == port, req,
        {cap_port[n][15:0], cap_data[n]}, {16'(port), e});
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    checks++;
    fails++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    int bad;
    int n;
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    chk(!mem_req && out_valid == 0, "R1", {mem_req, out_valid}, 0);
    chk(!share_valid && !mtx_req && !mtx_rel, "R1", {share_valid, mtx_req, mtx_rel}, 0);

    // R2 write waits for its data token
    send(16'h2000 | 16'd200);
    bad = 0;
    repeat (6) begin
      @(negedge clk);
      if (mem_req) bad++;
    end
    chk(bad == 0, "R2 no data no request", bad, 0);
    send(16'h1234);
    exp_acc++;
    rd_chk(200, 16'h1234, 0, "R2");

    // R2 / R3 sweep
    for (int a = 0; a < 32; a++) wr(a, pat(a, 1));
    for (int a = 0; a < 32; a++) rd_chk(a, pat(a, 1), 0, "R3 sweep");

    // R3 no room: read not accepted
    n = out_cnt;
    @(posedge clk); #1;
    out_room  = 4'b1110;
    tok_valid = 1'b1;
    tok_data  = 16'h0003;
    bad = 0;
    repeat (5) begin
      @(negedge clk);
      if (mem_req || tok_ready) bad++;
    end
    chk(bad == 0 && out_cnt == n, "R3 room", bad, 0);
    @(posedge clk); #1 out_room = '1;
    @(negedge clk);
    while (!tok_ready) @(negedge clk);
    @(posedge clk); #1 tok_valid = 1'b0;
    exp_acc++;
    wait_out(n + 1);
    chk(cap_data[n] == pat(3, 1), "R3 after room", cap_data[n], pat(3, 1));

    // R4 destination queue 2
    send(16'h4000 | (16'd2 << 2));
    rd_chk(7, pat(7, 1), 2, "R4");
    send(16'h4000);
    rd_chk(8, pat(8, 1), 0, "R4 back");

    // R5 address-only, partner 1
    send(16'h4000 | (16'd1 << 4) | 16'd1);
    fork
      for (int a = 40; a < 48; a++) send(16'h2000 | 16'(a));
      for (int a = 40; a < 48; a++) send_peer(1, pat(a, 2));
    join
    exp_acc += 8;
    send(16'h4000);
    for (int a = 40; a < 48; a++) rd_chk(a, pat(a, 2), 0, "R5");

    // R6 data-only pass-through
    n = rel_cnt;
    send(16'h4002);
    send(16'h0011);
    send(16'hE123);
    send(16'h4000);
    chk(share_cnt == 2, "R6 share count", share_cnt, 2);
    chk(shr_data[0] == 16'h0011 && shr_data[1] == 16'hE123, "R6 share data",
        {shr_data[0], shr_data[1]}, 32'h0011E123);
    chk(rel_cnt == n, "R6 not executed", rel_cnt, n);
    rd_chk(0, pat(0, 1), 0, "R6 mode restored");

    // R8 / R9 burst write from pointer 0x80
    send(16'h6080);
    send(16'hA000);
    send(16'd8);
    for (int i = 0; i < 8; i++) send(pat(i, 3));
    exp_acc += 8;
    // R7 burst read
    send(16'h6080);
    n = out_cnt;
    send(16'h8000);
    send(16'd8);
    exp_acc += 8;
    wait_out(n + 8);
    for (int i = 0; i < 8; i++)
      chk(cap_data[n+i] == pat(i, 3), "R7 R8 burst", cap_data[n+i], pat(i, 3));
    // R9 pointer continues at 0x88
    send(16'hA000);
    send(16'd4);
    for (int i = 0; i < 4; i++) send(pat(i, 4));
    exp_acc += 4;
    for (int i = 0; i < 4; i++) rd_chk(136 + i, pat(i, 4), 0, "R9");
    // R7 zero length
    n = out_cnt;
    send(16'h8000);
    send(16'd0);
    rd_chk(1, pat(1, 1), 0, "R7 zero length");
    chk(out_cnt == n + 1, "R7 zero length count", out_cnt, n + 1);

    // R10 lock blocks
    send(16'hC002);
    n = out_cnt;
    @(posedge clk); #1;
    tok_valid = 1'b1;
    tok_data  = 16'h0005;
    bad = 0;
    repeat (5) begin
      @(negedge clk);
      if (!mtx_req || mtx_id != 2'd2 || tok_ready) bad++;
    end
    chk(bad == 0, "R10 lock blocks", bad, 0);
    @(posedge clk); #1 mtx_gnt = 1'b1;
    @(posedge clk); #1 mtx_gnt = 1'b0;
    @(negedge clk);
    while (!tok_ready) @(negedge clk);
    @(posedge clk); #1 tok_valid = 1'b0;
    exp_acc++;
    wait_out(n + 1);
    chk(cap_data[n] == pat(5, 1), "R10 after grant", cap_data[n], pat(5, 1));

    // R11 release pulse
    n = rel_cnt;
    send(16'hE003);
    repeat (4) @(negedge clk);
    chk(rel_cnt == n + 1 && rel_id == 2'd3, "R11", {rel_cnt, rel_id}, {n + 1, 2'd3});

    // R12 one granted access per word
    repeat (4) @(negedge clk);
    chk(acc_cnt == exp_acc, "R12 access count", acc_cnt, exp_acc);

    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule